// File: doc/BRIEF.md
# DDR2 Burst Read Output Sequencer

This block is a cycle-level model of the memory-side read path of a DDR2-style SDRAM. At every rising clock edge it decodes the command pins. Two of the decoded commands matter here: a burst read, and a write to one of two configuration registers. The first configuration register holds the column-strobe latency and the burst length. The second holds an extra latency that is added to it. The sum of the two is the read latency.

When a read is accepted, the block captures the column address and the latency settings in force at that edge. One clock before the first data beat it drives the strobe low as a preamble. It then presents two beats per clock from a small internal array: a rise-beat word and a fall-beat word, with the strobe marked as toggling. After the last beat it releases the data and strobe drives. The beat order wraps inside the aligned block that holds the starting column. A read that arrives while a burst is pending or running is refused, and an error flag pulses for one cycle. A simple load port fills the array.

Top module: `ddr_rd_seq`

## Requirements
- R1: While `rst` is high and after it is released, `dq_oe`, `dqs_oe`, `dqs_lvl` and `rd_err` are 0 and both data words are 0. The settings after reset are column latency 3, added latency 0 and burst length 4.
- R2: A read is recognised only when `cs_n`=0, `cas_n`=0, `ras_n`=1 and `we_n`=1 at a rising edge. Any other pin pattern (for example `cs_n`=1, or `ras_n`=0 with `cas_n`=0 and `we_n`=1) starts no burst and raises no error.
- R3: A configuration write needs all four command pins low. With `ba`=0, `addr[2:0]` sets the column latency (legal values 3 to 5) and `addr[3]`=1 selects burst length 8 (0 selects 4). With `ba`=1, `addr[2:0]` sets the added latency (legal values 0 to 4). A write with an out-of-range latency value is ignored as a whole.
- R4: With RL = added latency + column latency, the first data pair is on the outputs after clock edge RL, counting the read edge as edge 0. Before edge RL-1 neither drive is enabled.
- R5: After edge RL-1, and for that one cycle only, `dqs_oe`=1 and `dqs_lvl`=0 while `dq_oe`=0 (the preamble).
- R6: During each data cycle `dq_oe`, `dqs_oe` and `dqs_lvl` are all 1. `dq_rise` carries beat 2i and `dq_fall` carries beat 2i+1 of pair i. A length-4 burst lasts 2 cycles and a length-8 burst lasts 4 cycles.
- R7: Beat j reads the column whose low log2(BL) bits equal (start + j) mod BL, with the upper bits of the start column kept.
- R8: After edge RL+BL/2, `dq_oe`, `dqs_oe` and `dqs_lvl` are 0, and the data words are 0 whenever `dq_oe` is 0.
- R9: A read sampled at edges 1 through RL+BL/2-1 of an accepted burst is refused. `rd_err` is 1 for exactly the cycle after that edge, and the running burst is unchanged. A read at edge RL+BL/2 is accepted.
- R10: When `ld_en` is 1 at a rising edge, `ld_data` is written to the array entry at `ld_addr`. Later bursts return the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write-enable command pin |
| ba | input | 1 | Configuration register select |
| addr | input | COL_W | Start column, or configuration value |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | COL_W | Array load address |
| ld_data | input | DQ_W | Array load data |
| dq_rise | output | DQ_W | Beat sent on the strobe's rising edge |
| dq_fall | output | DQ_W | Beat sent on the strobe's falling edge |
| dq_oe | output | 1 | Data drive enable |
| dqs_oe | output | 1 | Strobe drive enable |
| dqs_lvl | output | 1 | Strobe level: 0 preamble, 1 toggling |
| rd_err | output | 1 | One-cycle pulse for a refused read |

## Verification
Each read is driven for one clock. The rising edge that samples it is counted as edge 0, and the outputs are compared after every later edge up to RL+BL/2. The preamble is due after edge RL-1, data pair i after edge RL+i, and the release after edge RL+BL/2. A refused read must show `rd_err` after the same edge that sampled it, and never in the cycles around it. Inputs change on the falling edge and outputs are read on the next falling edge, so every sample falls exactly one registered edge after the stimulus it depends on. Configuration writes are followed by an idle clock before the next read, so each burst uses settings that are already in force.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

    localparam int unsigned LAT_W        = 4;
    localparam int unsigned BEATS_PER_CK = 2;
    localparam logic [2:0]  CL_LO        = 3'd3;
    localparam logic [2:0]  CL_HI        = 3'd5;
    localparam logic [2:0]  AL_HI        = 3'd4;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_READ,
        CMD_MODE,
        CMD_OTHER
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAT,
        ST_DATA
    } seq_st_e;

    typedef struct packed {
        logic [LAT_W-1:0] rl;
        logic             bl8;
    } rd_cfg_t;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        if (cs_n)                       return CMD_NOP;
        if (!ras_n && !cas_n && !we_n)  return CMD_MODE;
        if (ras_n && !cas_n && we_n)    return CMD_READ;
        if (ras_n && cas_n && we_n)     return CMD_NOP;
        return CMD_OTHER;
    endfunction

    function automatic logic cl_ok(input logic [2:0] v);
        return (v >= CL_LO) && (v <= CL_HI);
    endfunction

    function automatic logic al_ok(input logic [2:0] v);
        return v <= AL_HI;
    endfunction

endpackage

// File: rtl/ddr_mode_regs.sv
module ddr_mode_regs
    import ddr_rd_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic              ba,
    input  logic [ADDR_W-1:0] addr,
    output rd_cfg_t           cfg,
    output logic [2:0]        cl_val,
    output logic [2:0]        al_val
);

    logic [2:0] cl_q;
    logic [2:0] al_q;
    logic       bl8_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cl_q  <= CL_LO;
            al_q  <= 3'd0;
            bl8_q <= 1'b0;
        end else if (cmd == CMD_MODE) begin
            if (!ba) begin
                if (cl_ok(addr[2:0])) begin
                    cl_q  <= addr[2:0];
                    bl8_q <= addr[3];
                end
            end else if (al_ok(addr[2:0])) begin
                al_q <= addr[2:0];
            end
        end
    end

    always_comb begin
        cfg.rl  = LAT_W'(cl_q) + LAT_W'(al_q);
        cfg.bl8 = bl8_q;
    end

    assign cl_val = cl_q;
    assign al_val = al_q;

endmodule

// File: rtl/ddr_data_store.sv
module ddr_data_store #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned N_RD   = 2
) (
    input  logic              clk,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] rd_addr [N_RD],
    output logic [DATA_W-1:0] rd_data [N_RD]
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en) cells[ld_addr] <= ld_data;
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        assign rd_data[p] = cells[rd_addr[p]];
    end

endmodule

// File: rtl/ddr_burst_ctrl.sv
module ddr_burst_ctrl
    import ddr_rd_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  rd_cfg_t           cfg,
    output logic [ADDR_W-1:0] rd_addr [BEATS_PER_CK],
    input  logic [DATA_W-1:0] rd_data [BEATS_PER_CK],
    output logic [DATA_W-1:0] dq_rise,
    output logic [DATA_W-1:0] dq_fall,
    output logic              dq_oe,
    output logic              dqs_oe,
    output logic              dqs_lvl,
    output logic              rd_err,
    output logic              busy
);

    seq_st_e          state;
    logic [LAT_W-1:0] wait_q;
    logic [1:0]       pair_q;
    logic [ADDR_W-1:0] start_q;
    logic             bl8_q;
    logic [1:0]       last_pair;

    function automatic logic [ADDR_W-1:0] beat_col(input logic [ADDR_W-1:0] base,
                                                   input logic [2:0] beat,
                                                   input logic long_b);
        logic [ADDR_W-1:0] c;
        c = base;
        if (long_b) c[2:0] = base[2:0] + beat;
        else        c[1:0] = base[1:0] + beat[1:0];
        return c;
    endfunction

    assign last_pair = bl8_q ? 2'd3 : 2'd1;
    assign busy      = (state != ST_IDLE);

    for (genvar b = 0; b < BEATS_PER_CK; b++) begin : g_addr
        assign rd_addr[b] = beat_col(start_q, {pair_q, 1'(b)}, bl8_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            wait_q  <= '0;
            pair_q  <= '0;
            start_q <= '0;
            bl8_q   <= 1'b0;
            dq_rise <= '0;
            dq_fall <= '0;
            dq_oe   <= 1'b0;
            dqs_oe  <= 1'b0;
            dqs_lvl <= 1'b0;
            rd_err  <= 1'b0;
        end else begin
            dq_rise <= '0;
            dq_fall <= '0;
            dq_oe   <= 1'b0;
            dqs_oe  <= 1'b0;
            dqs_lvl <= 1'b0;
            rd_err  <= (cmd == CMD_READ) && (state != ST_IDLE);
            case (state)
                ST_IDLE: begin
                    if (cmd == CMD_READ) begin
                        state   <= ST_LAT;
                        wait_q  <= cfg.rl - LAT_W'(1);
                        start_q <= addr;
                        bl8_q   <= cfg.bl8;
                    end
                end
                ST_LAT: begin
                    if (wait_q == LAT_W'(1)) begin
                        dqs_oe <= 1'b1;
                        pair_q <= '0;
                        state  <= ST_DATA;
                    end else begin
                        wait_q <= wait_q - LAT_W'(1);
                    end
                end
                ST_DATA: begin
                    dq_rise <= rd_data[0];
                    dq_fall <= rd_data[1];
                    dq_oe   <= 1'b1;
                    dqs_oe  <= 1'b1;
                    dqs_lvl <= 1'b1;
                    pair_q  <= pair_q + 2'd1;
                    if (pair_q == last_pair) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq
    import ddr_rd_pkg::*;
#(
    parameter int unsigned COL_W = 6,
    parameter int unsigned DQ_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             ba,
    input  logic [COL_W-1:0] addr,
    input  logic             ld_en,
    input  logic [COL_W-1:0] ld_addr,
    input  logic [DQ_W-1:0]  ld_data,
    output logic [DQ_W-1:0]  dq_rise,
    output logic [DQ_W-1:0]  dq_fall,
    output logic             dq_oe,
    output logic             dqs_oe,
    output logic             dqs_lvl,
    output logic             rd_err
);

    cmd_e             cmd;
    rd_cfg_t          cfg;
    logic [2:0]       cl_w;
    logic [2:0]       al_w;
    logic             busy_w;
    logic [COL_W-1:0] col_w [BEATS_PER_CK];
    logic [DQ_W-1:0]  word_w [BEATS_PER_CK];

    always_comb cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);

    ddr_mode_regs #(.ADDR_W(COL_W)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .ba     (ba),
        .addr   (addr),
        .cfg    (cfg),
        .cl_val (cl_w),
        .al_val (al_w)
    );

    ddr_data_store #(.ADDR_W(COL_W), .DATA_W(DQ_W), .N_RD(BEATS_PER_CK)) u_store (
        .clk     (clk),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .rd_addr (col_w),
        .rd_data (word_w)
    );

    ddr_burst_ctrl #(.ADDR_W(COL_W), .DATA_W(DQ_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .addr    (addr),
        .cfg     (cfg),
        .rd_addr (col_w),
        .rd_data (word_w),
        .dq_rise (dq_rise),
        .dq_fall (dq_fall),
        .dq_oe   (dq_oe),
        .dqs_oe  (dqs_oe),
        .dqs_lvl (dqs_lvl),
        .rd_err  (rd_err),
        .busy    (busy_w)
    );

endmodule

// File: rtl/ddr_rd_seq_chk.sv
module ddr_rd_seq_chk #(
    parameter int unsigned DQ_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            cs_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic [DQ_W-1:0] dq_rise,
    input logic [DQ_W-1:0] dq_fall,
    input logic            dq_oe,
    input logic            dqs_oe,
    input logic            dqs_lvl,
    input logic            rd_err,
    input logic [2:0]      cl_val,
    input logic [2:0]      al_val,
    input logic            busy
);

    p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> ($past(!cs_n && ras_n && !cas_n && we_n) && $past(busy)));

    p_preamble_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> ($past(dqs_oe) && !$past(dqs_lvl)));

    p_strobe_with_data_r6: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (dqs_oe && dqs_lvl));

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(dq_oe) |-> (!dqs_oe && !dqs_lvl));

    p_quiet_bus_r8: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> (dq_rise == '0 && dq_fall == '0));

    p_lat_range_r3: assert property (@(posedge clk) disable iff (rst)
        (cl_val >= 3'd3) && (cl_val <= 3'd5) && (al_val <= 3'd4));

    p_drive_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        dqs_oe |-> $past(busy));

endmodule

bind ddr_rd_seq ddr_rd_seq_chk #(.DQ_W(DQ_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .dq_rise (dq_rise),
    .dq_fall (dq_fall),
    .dq_oe   (dq_oe),
    .dqs_oe  (dqs_oe),
    .dqs_lvl (dqs_lvl),
    .rd_err  (rd_err),
    .cl_val  (cl_w),
    .al_val  (al_w),
    .busy    (busy_w)
);

// File: tb/ddr_rd_seq_tb.sv
module ddr_rd_seq_tb;

    localparam int COL_W = 6;
    localparam int DQ_W  = 8;
    localparam int DEPTH = 1 << COL_W;
    localparam time CLK_P = 20ns;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic             ba = 1'b0;
    logic [COL_W-1:0] addr = '0;
    logic             ld_en = 1'b0;
    logic [COL_W-1:0] ld_addr = '0;
    logic [DQ_W-1:0]  ld_data = '0;
    logic [DQ_W-1:0]  dq_rise, dq_fall;
    logic             dq_oe, dqs_oe, dqs_lvl, rd_err;

    logic [DQ_W-1:0]  mem_m [DEPTH];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ddr_rd_seq #(.COL_W(COL_W), .DQ_W(DQ_W)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
        .dqs_lvl(dqs_lvl), .rd_err(rd_err)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic nop();
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic drive_read(input int col);
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1;
        addr = COL_W'(col);
    endtask

    task automatic mode_wr(input bit sel, input int val);
        cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0;
        ba = sel; addr = COL_W'(val);
        tick();
        nop();
        tick();
    endtask

    function automatic int wrap_col(input int col, input int j, input int bl);
        int m;
        m = bl - 1;
        return (col & ~m) | ((col + j) & m);
    endfunction

    // One burst, counted from its read edge (edge 0). 'pre' means edge 0 was
    // already driven by the previous call; 'poke' sends a refused read at that edge.
    task automatic burst(input int col, input int rl, input int bl, input int poke,
                         input bit chain, input int ncol, input bit pre, input string dtag);
        int last;
        last = rl + bl / 2;
        for (int k = (pre ? 1 : 0); k <= last; k++) begin
            if (k == 0)                    drive_read(col);
            else if (k == poke)            drive_read(col ^ 32);
            else if (chain && k == last)   drive_read(ncol);
            else                           nop();
            tick();
            nop();
            if (k == 0) continue;
            chk(rd_err, (k == poke), "R9", "rd_err pulse");
            if (k < rl - 1) begin
                chk(dqs_oe, 0, "R4", "strobe idle during latency");
                chk(dq_oe, 0, "R4", "data idle during latency");
            end else if (k == rl - 1) begin
                chk(dqs_oe, 1, "R5", "preamble strobe enable");
                chk(dqs_lvl, 0, "R5", "preamble strobe low");
                chk(dq_oe, 0, "R5", "no data in preamble");
            end else if (k < last) begin
                int i;
                i = k - rl;
                chk(dq_oe, 1, "R4", "data enable at latency");
                chk({dqs_oe, dqs_lvl}, 2'b11, "R6", "strobe toggling with data");
                chk(dq_rise, mem_m[wrap_col(col, 2*i, bl)], dtag, "rise beat");
                chk(dq_fall, mem_m[wrap_col(col, 2*i+1, bl)], dtag, "fall beat");
            end else begin
                chk(dq_oe, 0, "R8", "data released");
                chk(dqs_oe, 0, "R8", "strobe released");
                chk(dqs_lvl, 0, "R8", "strobe level cleared");
            end
        end
    endtask

    task automatic t_reset();
        chk({dq_oe, dqs_oe, dqs_lvl, rd_err}, 0, "R1", "enables during reset");
        rst = 1'b0;
        tick();
        chk({dq_oe, dqs_oe, dqs_lvl, rd_err}, 0, "R1", "enables after reset");
        chk({dq_rise, dq_fall}, 0, "R1", "data words after reset");
    endtask

    task automatic t_preload();
        for (int a = 0; a < DEPTH; a++) begin
            ld_en = 1'b1; ld_addr = COL_W'(a); ld_data = DQ_W'(a * 29 + 7);
            mem_m[a] = DQ_W'(a * 29 + 7);
            tick();
        end
        ld_en = 1'b0;
        tick();
    endtask

    task automatic t_default();
        // reset settings: CL 3, AL 0, BL 4 -> beats 5,6,7,4
        burst(5, 3, 4, 0, 1'b0, 0, 1'b0, "R1");
        tick();
    endtask

    task automatic t_nonread();
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1; addr = 6'd3;
        tick();
        cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b1;
        tick();
        nop();
        for (int k = 0; k < 10; k++) begin
            tick();
            chk({dq_oe, dqs_oe, rd_err}, 0, "R2", "no burst from non-read pattern");
        end
    endtask

    task automatic t_mode();
        mode_wr(1'b0, 13);   // CL 5, BL 8
        mode_wr(1'b1, 2);    // AL 2 -> RL 7
        burst(19, 7, 8, 0, 1'b0, 0, 1'b0, "R7");
        tick();
    endtask

    task automatic t_illegal();
        mode_wr(1'b0, 6);    // CL 6 with BL 4: whole write ignored (R3)
        mode_wr(1'b0, 2);    // CL 2: ignored (R3)
        mode_wr(1'b1, 5);    // AL 5: ignored (R3)
        burst(42, 7, 8, 0, 1'b0, 0, 1'b0, "R3");
        tick();
    endtask

    task automatic t_reject();
        mode_wr(1'b0, 3);    // CL 3, BL 4
        mode_wr(1'b1, 0);    // AL 0
        ld_en = 1'b1; ld_addr = 6'd9; ld_data = 8'hC3;
        tick();
        ld_en = 1'b0;
        mem_m[9] = 8'hC3;
        burst(8, 3, 4, 2, 1'b1, 13, 1'b0, "R10");
        burst(13, 3, 4, 0, 1'b0, 0, 1'b1, "R7");
        mode_wr(1'b0, 13);   // CL 5, BL 8, AL 0 -> RL 5
        burst(30, 5, 8, 6, 1'b0, 0, 1'b0, "R9");
        tick();
    endtask

    initial begin
        nop();
        repeat (3) tick();
        t_reset();
        t_preload();
        t_default();
        t_nonread();
        t_mode();
        t_illegal();
        t_reject();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R4: actual=hung expected=completed");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule